// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block holds the digital routing setup for a crosspoint matrix with eight outputs and eight inputs. Each output owns a 4-bit control field. The fields sit in a 32-bit staging register, which can be loaded in two ways. In serial mode, one bit enters per clock and the far end of the register is driven out on a serial pin, so several controllers can be chained. In parallel mode, a single field, chosen by a 3-bit output address, is overwritten with a 4-bit word and the other fields stay as they were.

An update strobe copies the staging register into a holding latch. Only the latch feeds the per-output decoders. Each decoder turns its field into eight one-hot input-select lines and an output-enable line for the analog switch and buffer that follow. An asynchronous reset turns every output off. A chip-enable gates all shifting and writing.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, every `oen_o` bit, every `sel_o` bit and `ser_out` read 0.
- R2: With `ce_n` low and `par_mode` 0 (serial), each rising clock edge moves the staging register one place toward bit 31, loads `ser_in` into bit 0 and presents the bit that is now at bit 31 on `ser_out`. The field for output n is bits [4n+3:4n], so the field for output 7 is shifted in first, most significant bit first.
- R3: With `ce_n` low and `par_mode` 1 (parallel), a clock edge writes `wr_data` into the field of output `wr_addr` and leaves the other seven fields unchanged.
- R4: With `ce_n` high, a clock edge changes neither the staging register nor `ser_out`, in either mode.
- R5: The decoded outputs change only on a clock edge where `upd_n` is low. That edge copies the staging register into the latch, and it does so whatever the level of `ce_n`.
- R6: In a latched field, bit 3 is the enable and bits [2:0] are the input index. When the enable is 1, `oen_o[n]` is 1 and `sel_o[8n+k]` is 1 only for k equal to the index.
- R7: A latched field whose enable bit is 0 drives `oen_o[n]` to 0 and all eight of its select lines to 0.
- R8: A parallel write and `upd_n` low on the same edge latch the newly written field.
- R9: Driving `rst_n` low turns all outputs off at once, with no clock edge needed, and clears both the staging register and the latch. An update after reset, with no new load, leaves every output off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for shifting, writes and update |
| rst_n | input | 1 | Asynchronous reset, active low: all outputs off |
| ce_n | input | 1 | Chip enable, active low, gates shift and write |
| upd_n | input | 1 | Update strobe, active low, copies staging to latch |
| par_mode | input | 1 | 0 = serial load, 1 = addressed parallel load |
| ser_in | input | 1 | Serial data entering staging bit 0 |
| wr_addr | input | 3 | Output whose field a parallel write targets |
| wr_data | input | 4 | Field value for a parallel write |
| ser_out | output | 1 | Staging bit 31, for chaining |
| sel_o | output | 64 | One-hot input selects, 8 per output, output n at [8n+7:8n] |
| oen_o | output | 8 | Output buffer enables, one per output |

## Verification
A corrupted staging register does not show on the decoded outputs until the next update. It does show on `ser_out` within the cycles it takes the bad bit to reach bit 31, so the bench checks `ser_out` on every serial shift and follows each load with an update and a full comparison of `sel_o` and `oen_o`. A wrong latch shows at once in the select and enable lines. A select bit lit while its enable is clear, or two selects lit together for one output, shows within a cycle of that latch value. A missed gate on `ce_n`, or a write that spills into a neighbouring field, shows at the next update.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
   typedef enum logic {
      LOAD_SERIAL   = 1'b0,
      LOAD_PARALLEL = 1'b1
   } load_mode_e;
endpackage

// File: rtl/xpt_stage_reg.sv
module xpt_stage_reg
   import xpt_cfg_pkg::*;
#(
   parameter int NUM_OUT = 8,
   parameter int FIELD_W = 4,
   localparam int REG_W  = NUM_OUT * FIELD_W,
   localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce_n,
   input  load_mode_e         mode,
   input  logic               ser_in,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [FIELD_W-1:0] wr_data,
   output logic [REG_W-1:0]   stage_q,
   output logic [REG_W-1:0]   stage_d,
   output logic               ser_out
);
   logic [REG_W-1:0] par_next;

   // one write lane per field: only the addressed field takes wr_data
   for (genvar f = 0; f < NUM_OUT; f++) begin : g_lane
      always_comb begin
         if (int'(wr_addr) == f)
            par_next[f*FIELD_W +: FIELD_W] = wr_data;
         else
            par_next[f*FIELD_W +: FIELD_W] = stage_q[f*FIELD_W +: FIELD_W];
      end
   end

   always_comb begin
      stage_d = stage_q;
      if (!ce_n) begin
         if (mode == LOAD_PARALLEL)
            stage_d = par_next;
         else
            stage_d = {stage_q[REG_W-2:0], ser_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage_q <= '0;
      else
         stage_q <= stage_d;
   end

   assign ser_out = stage_q[REG_W-1];
endmodule

// File: rtl/xpt_hold_latch.sv
module xpt_hold_latch #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_n,
   input  logic [REG_W-1:0] stage_d,
   output logic [REG_W-1:0] hold_q
);
   // takes the staging value as it stands after this edge's load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (!upd_n)
         hold_q <= stage_d;
   end
endmodule

// File: rtl/xpt_out_decoder.sv
module xpt_out_decoder #(
   parameter int NUM_IN = 8,
   localparam int SEL_W   = $clog2(NUM_IN),
   localparam int FIELD_W = SEL_W + 1
) (
   input  logic [FIELD_W-1:0] field,
   output logic [NUM_IN-1:0]  sel,
   output logic               oen
);
   logic [SEL_W-1:0] idx;

   assign idx = field[SEL_W-1:0];
   assign oen = field[FIELD_W-1];

   always_comb begin
      sel = '0;
      if (oen)
         sel[idx] = 1'b1;
   end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
   import xpt_cfg_pkg::*;
#(
   parameter int NUM_OUT = 8,
   parameter int NUM_IN  = 8,
   localparam int SEL_W   = $clog2(NUM_IN),
   localparam int FIELD_W = SEL_W + 1,
   localparam int REG_W   = NUM_OUT * FIELD_W,
   localparam int ADDR_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ce_n,
   input  logic                      upd_n,
   input  logic                      par_mode,
   input  logic                      ser_in,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [FIELD_W-1:0]        wr_data,
   output logic                      ser_out,
   output logic [NUM_OUT*NUM_IN-1:0] sel_o,
   output logic [NUM_OUT-1:0]        oen_o
);
   if (NUM_IN < 2 || NUM_IN != (1 << SEL_W)) begin : g_bad_in
      $error("xpt_cfg_ctrl: NUM_IN must be a power of two, at least 2");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("xpt_cfg_ctrl: NUM_OUT must be at least 1");
   end

   logic [REG_W-1:0] stage_q;
   logic [REG_W-1:0] stage_d;
   logic [REG_W-1:0] hold_q;
   load_mode_e       mode;

   assign mode = par_mode ? LOAD_PARALLEL : LOAD_SERIAL;

   xpt_stage_reg #(
      .NUM_OUT (NUM_OUT),
      .FIELD_W (FIELD_W)
   ) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .mode    (mode),
      .ser_in  (ser_in),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .stage_q (stage_q),
      .stage_d (stage_d),
      .ser_out (ser_out)
   );

   xpt_hold_latch #(
      .REG_W (REG_W)
   ) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_n   (upd_n),
      .stage_d (stage_d),
      .hold_q  (hold_q)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_dec
      xpt_out_decoder #(
         .NUM_IN (NUM_IN)
      ) dec_i (
         .field (hold_q[o*FIELD_W +: FIELD_W]),
         .sel   (sel_o[o*NUM_IN +: NUM_IN]),
         .oen   (oen_o[o])
      );
   end
endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk #(
   parameter int NUM_OUT = 8,
   parameter int NUM_IN  = 8,
   localparam int SEL_W   = $clog2(NUM_IN),
   localparam int FIELD_W = SEL_W + 1,
   localparam int REG_W   = NUM_OUT * FIELD_W
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ce_n,
   input logic                      upd_n,
   input logic                      par_mode,
   input logic                      ser_in,
   input logic                      ser_out,
   input logic [NUM_OUT*NUM_IN-1:0] sel_o,
   input logic [NUM_OUT-1:0]        oen_o,
   input logic [REG_W-1:0]          stage_q
);
   // R1
   reset_off_chk: assert property (@(posedge clk)
      !rst_n |-> (oen_o == '0 && sel_o == '0 && !ser_out));

   // R2
   serial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !par_mode) |=> (stage_q[0] == $past(ser_in)) &&
                               (ser_out == $past(stage_q[REG_W-2])));

   // R4
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> $stable(stage_q) && $stable(ser_out));

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_n |=> $stable(sel_o) && $stable(oen_o));

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      // R6
      sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(sel_o[o*NUM_IN +: NUM_IN]));
      // R7
      sel_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|sel_o[o*NUM_IN +: NUM_IN]) == oen_o[o]);
   end
endmodule

bind xpt_cfg_ctrl xpt_cfg_chk #(
   .NUM_OUT (NUM_OUT),
   .NUM_IN  (NUM_IN)
) chk_i (.*);

// File: tb/xpt_cfg_ctrl_tb_top.sv
module xpt_cfg_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        ce_n = 1'b1;
   logic        upd_n = 1'b1;
   logic        par_mode = 1'b0;
   logic        ser_in = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [3:0]  wr_data = '0;
   logic        ser_out;
   logic [63:0] sel_o;
   logic [7:0]  oen_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      logic [63:0] sel;
      logic [7:0]  oen;
      logic        ser;
   } exp_t;

   exp_t expq[$];
   event chk_ev;

   logic [31:0] stage_m = '0;
   logic [31:0] latch_m = '0;

   always #10 clk = ~clk;

   xpt_cfg_ctrl dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .upd_n    (upd_n),
      .par_mode (par_mode),
      .ser_in   (ser_in),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ser_out  (ser_out),
      .sel_o    (sel_o),
      .oen_o    (oen_o)
   );

   // expected outputs from a latched word: bit 3 of a field enables, bits 2:0 pick the input
   task automatic push_exp(input string tag);
      exp_t it;
      it.tag = tag;
      it.sel = '0;
      it.oen = '0;
      for (int n = 0; n < 8; n++) begin
         if (latch_m[4*n+3]) begin
            it.oen[n] = 1'b1;
            it.sel[8*n + int'(latch_m[4*n +: 3])] = 1'b1;
         end
      end
      it.ser = stage_m[31];
      expq.push_back(it);
      -> chk_ev;
   endtask

   // called at a falling edge; drives, applies one rising edge, queues the expectation
   task automatic step(input string tag, input logic ce, input logic upd, input logic pm,
                       input logic sin, input logic [2:0] a, input logic [3:0] d);
      logic [31:0] nxt;
      ce_n = ce; upd_n = upd; par_mode = pm; ser_in = sin; wr_addr = a; wr_data = d;
      nxt = stage_m;
      if (!ce) begin
         if (pm) nxt[4*int'(a) +: 4] = d;
         else    nxt = {stage_m[30:0], sin};
      end
      stage_m = nxt;
      if (!upd) latch_m = nxt;
      @(posedge clk);
      @(negedge clk);
      push_exp(tag);
   endtask

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (expq.size() > 0) begin
            exp_t it;
            it = expq.pop_front();
            checks++;
            if (sel_o !== it.sel || oen_o !== it.oen || ser_out !== it.ser) begin
               failures++;
               $display("FAIL %s: sel=%h oen=%b ser=%b expected sel=%h oen=%b ser=%b",
                        it.tag, sel_o, oen_o, ser_out, it.sel, it.oen, it.ser);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] word;
      #1 rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      push_exp("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R5: parallel write without update does not reach outputs
      step("R5 write held in staging", 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 4'b1101);
      step("R5 R6 update shows output 2 on input 5", 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0);
      // R8: write and update together
      step("R8 same-edge write and update", 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 4'b1011);
      // R3: field 7 and field 0 writes leave others
      step("R3 write field 0", 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 4'b1111);
      step("R3 write field 7", 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 4'b1000);
      // R7: disable output 2
      step("R7 disabled field turns output off", 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 4'b0011);
      // R4: ce_n high blocks the write, update relatches unchanged value
      step("R4 write ignored with ce_n high", 1'b1, 1'b0, 1'b1, 1'b0, 3'd6, 4'b0000);

      // R2: serial load, field n = enable with index 7-n, output 7 first, MSB first
      for (int n = 0; n < 8; n++) word[4*n +: 4] = {1'b1, 3'(7 - n)};
      for (int i = 31; i >= 0; i--)
         step("R2 serial shift ser_out", 1'b0, 1'b1, 1'b0, word[i], 3'd0, 4'd0);
      step("R2 R6 serial word latched", 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
      // R4: clocks with ce_n high in serial mode change nothing
      for (int i = 0; i < 3; i++)
         step("R4 serial ignored with ce_n high", 1'b1, 1'b1, 1'b0, 1'(i), 3'd0, 4'd0);
      step("R4 update after blocked shifts", 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
      // R2: daisy-chain output after further shifts
      for (int i = 0; i < 6; i++)
         step("R2 daisy-chain bits leave bit 31", 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0);

      // R9: asynchronous reset away from a clock edge
      #3 rst_n = 1'b0;
      stage_m = '0;
      latch_m = '0;
      #2 push_exp("R9 async reset turns outputs off");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      step("R9 update after reset keeps outputs off", 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
      step("R6 output 4 on input 0 after reset", 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 4'b1000);

      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule